// File: doc/BRIEF.md
# 8-bit Arithmetic-Logic Unit with Masked Status Flags

This block computes one 8-bit operation per clock on a destination operand and a source operand; the source may be a register value or an immediate. The result appears combinationally on the same cycle. A flag register holds carry, zero, negative, overflow, sign and half-carry. At each rising edge the register takes new values only for the flags that the current operation owns. All other flags keep their stored values. The stored carry is the carry-in for the carry-using arithmetic, rotates and word operations. The stored flags therefore chain from one operation to the next, with no separate carry input.

A word add or subtract of a zero-extended immediate to a 16-bit register pair runs as a two-clock sequence. The first edge captures the low-byte sum and the carry. The second edge forms the high byte and publishes the 16-bit result. While that sequence is in flight, the operation select is ignored.

Top module: `alu8_flags`

## Requirements
- R1: The flag vector has carry at bit 0, zero at bit 1, negative at bit 2, overflow at bit 3, sign at bit 4 and half-carry at bit 5. Synchronous active-low reset clears the flags, the word result, the busy output and the word-done output.
- R2: ADD gives a+b and ADC gives a+b+C (C is the stored carry). Both write all six flags: C is the carry out of bit 7, H is the carry out of bit 3, and V is the two's-complement overflow.
- R3: SUB gives a−b and SBC gives a−b−C. Both write all six flags: C is the borrow out of bit 7, H is the borrow into bit 4, and V is the two's-complement overflow.
- R4: AND, OR and XOR write Z, N and S and clear V. C and H keep their stored values.
- R5: COM gives 0xFF−a, sets C and clears V, and keeps H. NEG gives 0x00−a and writes all flags: C is set when the result is nonzero, V is set when the result is 0x80, and H is bit 3 of the result OR bit 3 of a.
- R6: INC gives a+1 and DEC gives a−1. Both write Z, N, V and S and keep C and H. V is set when INC yields 0x80 or DEC yields 0x7F.
- R7: LSL shifts left and fills bit 0 with 0. ROL shifts left and fills bit 0 with the stored C. Both load C from old bit 7 and H from old bit 3, and set V to N xor C.
- R8: LSR fills bit 7 with 0, ASR keeps bit 7, and ROR fills bit 7 with the stored C. All three load C from old bit 0, set V to N xor C, and keep H.
- R9: SWAP exchanges the two nibbles and NOP passes a through. Neither changes any flag.
- R10: Whenever N or V is written, S is written with N xor V in the same edge.
- R11: WADD/WSUB on the pair {hi,a} with immediate b hold busy high for exactly one cycle after the start edge. The next edge publishes the 16-bit result with a one-cycle done pulse and writes Z (16-bit zero), N (bit 15), V, C and S, keeping H. The operation select is ignored while busy.
- R12: The result is valid in the cycle the operation is applied. The flags change only at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 5 | Operation select (package enum `alu_op_e`) |
| opa_i | input | 8 | Destination operand; low byte of the pair for word ops |
| opa_hi_i | input | 8 | High byte of the register pair for word ops |
| opb_i | input | 8 | Source register value or immediate |
| res_o | output | 8 | Combinational byte result |
| flags_o | output | 6 | Registered flags {H,S,V,N,Z,C} |
| busy_o | output | 1 | Word operation in its second cycle |
| word_o | output | 16 | Registered word result |
| word_done_o | output | 1 | One-cycle pulse when word_o is updated |

## Verification
The flag register feeds its own carry back into ADC, SBC, ROL and ROR. A wrong stored flag therefore shows up twice. It is visible on flags_o right after the faulty edge, and on res_o in the first carry-consuming operation that follows. A mask that writes too many or too few flags is exposed at the next edge by operations whose untouched flags are preset to a value opposite to what a write would give. A word sequencer stuck busy, or one that skips its second cycle, shows up within two edges on busy_o, word_done_o and word_o. A corrupted captured low byte or carry shows up at the second edge of the word operation.

// File: rtl/alu8_pkg.sv
// Shared types for the 8-bit ALU: operation codes, flag positions and
// the update masks. Assumes the flag vector is ordered {H,S,V,N,Z,C}.
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADC  = 5'd2,
        OP_SUB  = 5'd3,
        OP_SBC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_COM  = 5'd8,
        OP_NEG  = 5'd9,
        OP_INC  = 5'd10,
        OP_DEC  = 5'd11,
        OP_LSL  = 5'd12,
        OP_ROL  = 5'd13,
        OP_LSR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_ROR  = 5'd16,
        OP_SWAP = 5'd17,
        OP_WADD = 5'd18,
        OP_WSUB = 5'd19
    } alu_op_e;

    localparam int NFLAG = 6;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef logic [NFLAG-1:0] flag_t;

    localparam flag_t M_ALL   = 6'b111111;
    localparam flag_t M_CZNVS = 6'b011111;
    localparam flag_t M_ZNVS  = 6'b011110;
    localparam flag_t M_NONE  = 6'b000000;

endpackage

// File: rtl/alu8_core.sv
// Combinational byte datapath: result, candidate flag values and the
// per-operation update mask. Assumes DW is even (nibble swap, half carry).
// Word operations and NOP return operand a with an empty mask.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output flag_t           fval,
    output flag_t           fmask
);
    localparam int MSB = DW - 1;
    localparam int HB  = DW / 2 - 1;
    localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

    logic [DW:0] ext;
    logic        c, h, v, use_c;

    // Select the operation and produce result, carry, half-carry, overflow.
    always_comb begin
        ext   = '0;
        res   = a;
        c     = 1'b0;
        h     = 1'b0;
        v     = 1'b0;
        fmask = M_NONE;
        use_c = (op == OP_ADC || op == OP_SBC) ? cin : 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                ext   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, use_c};
                res   = ext[DW-1:0];
                c     = ext[DW];
                h     = (a[HB] & b[HB]) | (b[HB] & ~res[HB]) | (~res[HB] & a[HB]);
                v     = (a[MSB] & b[MSB] & ~res[MSB]) | (~a[MSB] & ~b[MSB] & res[MSB]);
                fmask = M_ALL;
            end
            OP_SUB, OP_SBC: begin
                ext   = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, use_c};
                res   = ext[DW-1:0];
                c     = ext[DW];
                h     = (~a[HB] & b[HB]) | (b[HB] & res[HB]) | (res[HB] & ~a[HB]);
                v     = (a[MSB] & ~b[MSB] & ~res[MSB]) | (~a[MSB] & b[MSB] & res[MSB]);
                fmask = M_ALL;
            end
            OP_AND: begin res = a & b; fmask = M_ZNVS; end
            OP_OR:  begin res = a | b; fmask = M_ZNVS; end
            OP_XOR: begin res = a ^ b; fmask = M_ZNVS; end
            OP_COM: begin
                res   = ~a;
                c     = 1'b1;
                fmask = M_CZNVS;
            end
            OP_NEG: begin
                res   = '0 - a;
                c     = |res;
                v     = (res == MIN_NEG);
                h     = res[HB] | a[HB];
                fmask = M_ALL;
            end
            OP_INC: begin
                res   = a + 1'b1;
                v     = (res == MIN_NEG);
                fmask = M_ZNVS;
            end
            OP_DEC: begin
                res   = a - 1'b1;
                v     = (res == MAX_POS);
                fmask = M_ZNVS;
            end
            OP_LSL, OP_ROL: begin
                res   = {a[DW-2:0], (op == OP_ROL) ? cin : 1'b0};
                c     = a[MSB];
                h     = a[HB];
                v     = res[MSB] ^ a[MSB];
                fmask = M_ALL;
            end
            OP_LSR, OP_ASR, OP_ROR: begin
                if (op == OP_LSR)      res = {1'b0,   a[MSB:1]};
                else if (op == OP_ASR) res = {a[MSB], a[MSB:1]};
                else                   res = {cin,    a[MSB:1]};
                c     = a[0];
                v     = res[MSB] ^ a[0];
                fmask = M_CZNVS;
            end
            OP_SWAP: res = {a[HB:0], a[MSB:HB+1]};
            default: res = a;
        endcase
    end

    // Assemble candidate flag values; S always follows N xor V.
    always_comb begin
        fval     = '0;
        fval[FC] = c;
        fval[FZ] = (res == '0);
        fval[FN] = res[MSB];
        fval[FV] = v;
        fval[FS] = res[MSB] ^ v;
        fval[FH] = h;
    end

endmodule

// File: rtl/alu8_word.sv
// Two-cycle word add/subtract of a zero-extended immediate to a register
// pair. The start edge captures the low byte and its carry; the next edge
// finishes the high byte. Assumes start is only raised while idle.
module alu8_word
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            sub,
    input  logic [DW-1:0]   lo,
    input  logic [DW-1:0]   hi,
    input  logic [DW-1:0]   imm,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] word,
    output flag_t           fval,
    output flag_t           fmask
);
    localparam int MSB = DW - 1;

    logic          busy_q, done_q, sub_q, carry_q;
    logic [DW-1:0] lo_q, hi_q;
    logic [2*DW-1:0] word_q;
    logic [DW:0]   lo_ext, hi_ext;
    logic [2*DW-1:0] wres;
    logic          vw, cw;

    // Low byte and high-byte completion arithmetic.
    always_comb begin
        lo_ext = sub ? ({1'b0, lo} - {1'b0, imm}) : ({1'b0, lo} + {1'b0, imm});
        hi_ext = sub_q ? ({1'b0, hi_q} - {{DW{1'b0}}, carry_q})
                       : ({1'b0, hi_q} + {{DW{1'b0}}, carry_q});
        wres   = {hi_ext[DW-1:0], lo_q};
        vw     = sub_q ? (hi_q[MSB] & ~wres[2*DW-1]) : (~hi_q[MSB] & wres[2*DW-1]);
        cw     = sub_q ? (wres[2*DW-1] & ~hi_q[MSB]) : (~wres[2*DW-1] & hi_q[MSB]);
    end

    // Flags offered to the register; the mask is live only in the second cycle.
    always_comb begin
        fval     = '0;
        fval[FC] = cw;
        fval[FZ] = (wres == '0);
        fval[FN] = wres[2*DW-1];
        fval[FV] = vw;
        fval[FS] = wres[2*DW-1] ^ vw;
        fmask    = busy_q ? M_CZNVS : M_NONE;
    end

    // Sequence state: capture on start, publish one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            sub_q   <= 1'b0;
            carry_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            word_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                word_q <= wres;
                done_q <= 1'b1;
                busy_q <= 1'b0;
            end else if (start) begin
                lo_q    <= lo_ext[DW-1:0];
                carry_q <= lo_ext[DW];
                hi_q    <= hi;
                sub_q   <= sub;
                busy_q  <= 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign word = word_q;

    // R11: the busy phase lasts exactly one cycle and ends with a done pulse.
    a_r11_one_busy_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (!busy_q && done_q));

    // R11: a done pulse is always preceded by the busy phase.
    a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q));

endmodule

// File: rtl/alu8_flags.sv
// Top of the ALU: byte datapath, word sequencer and the masked flag
// register. The stored carry feeds the carry-consuming operations.
// Assumes op_i carries a valid alu_op_e code; it is ignored while busy.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      op_i,
    input  logic [DW-1:0]   opa_i,
    input  logic [DW-1:0]   opa_hi_i,
    input  logic [DW-1:0]   opb_i,
    output logic [DW-1:0]   res_o,
    output logic [5:0]      flags_o,
    output logic            busy_o,
    output logic [2*DW-1:0] word_o,
    output logic            word_done_o
);
    alu_op_e op;
    flag_t   flags_q, core_val, core_mask, word_val, word_mask, sel_val, sel_mask;
    logic    busy, word_start;

    assign op = alu_op_e'(op_i);
    assign word_start = !busy && (op == OP_WADD || op == OP_WSUB);

    alu8_core #(.DW(DW)) u_core (
        .op    (op),
        .a     (opa_i),
        .b     (opb_i),
        .cin   (flags_q[FC]),
        .res   (res_o),
        .fval  (core_val),
        .fmask (core_mask)
    );

    alu8_word #(.DW(DW)) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .start (word_start),
        .sub   (op == OP_WSUB),
        .lo    (opa_i),
        .hi    (opa_hi_i),
        .imm   (opb_i),
        .busy  (busy),
        .done  (word_done_o),
        .word  (word_o),
        .fval  (word_val),
        .fmask (word_mask)
    );

    // Pick the flag source: the word sequencer owns the busy cycle.
    always_comb begin
        sel_val  = busy ? word_val  : core_val;
        sel_mask = busy ? word_mask : core_mask;
    end

    // Flag register: write only the masked flags, keep the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~sel_mask) | (sel_val & sel_mask);
    end

    assign flags_o = flags_q;
    assign busy_o  = busy;

    // R10: the stored sign always agrees with the stored N and V.
    a_r10_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[FS] == (flags_q[FN] ^ flags_q[FV]));

    // R9: swap and no-op leave the flag register untouched.
    a_r9_swap_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (op == OP_SWAP || op == OP_NOP)) |=> $stable(flags_q));

    // R4: a logical operation leaves V cleared.
    a_r4_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !flags_q[FV]);

    // R5: one's complement always leaves carry set.
    a_r5_com_sets_c: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == OP_COM) |=> flags_q[FC]);

    // R11: the start edge of a word operation does not touch the flags.
    a_r11_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> $stable(flags_q));

endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
    import alu8_pkg::*;

    typedef struct packed {
        logic       pre;     // 0: preset flags 000010, 1: preset 100011
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] res;
        logic [5:0] fl;      // {H,S,V,N,Z,C}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, OP_ADD,  8'h3C, 8'h45, 8'h81, 6'b101100, 4'd2},  // R2 overflow, half carry
        '{1'b1, OP_ADC,  8'h10, 8'h20, 8'h31, 6'b000000, 4'd2},  // R2 stored carry used
        '{1'b0, OP_SUB,  8'h10, 8'h20, 8'hF0, 6'b010101, 4'd3},  // R3 borrow
        '{1'b1, OP_SBC,  8'h50, 8'h4F, 8'h00, 6'b100010, 4'd3},  // R3 borrow-in, zero
        '{1'b1, OP_SUB,  8'h80, 8'h01, 8'h7F, 6'b111000, 4'd3},  // R3 overflow
        '{1'b1, OP_AND,  8'hF0, 8'h0F, 8'h00, 6'b100011, 4'd4},  // R4 C,H kept
        '{1'b0, OP_OR,   8'h80, 8'h01, 8'h81, 6'b010100, 4'd4},  // R4
        '{1'b1, OP_XOR,  8'hAA, 8'h2A, 8'h80, 6'b110101, 4'd4},  // R4
        '{1'b0, OP_COM,  8'h55, 8'h00, 8'hAA, 6'b010101, 4'd5},  // R5 COM
        '{1'b0, OP_NEG,  8'h01, 8'h00, 8'hFF, 6'b110101, 4'd5},  // R5 NEG
        '{1'b1, OP_NEG,  8'h80, 8'h00, 8'h80, 6'b001101, 4'd5},  // R5 NEG of 0x80
        '{1'b1, OP_NEG,  8'h00, 8'h00, 8'h00, 6'b000010, 4'd5},  // R5 NEG of zero
        '{1'b1, OP_INC,  8'h7F, 8'h00, 8'h80, 6'b101101, 4'd6},  // R6 INC overflow
        '{1'b0, OP_DEC,  8'h80, 8'h00, 8'h7F, 6'b011000, 4'd6},  // R6 DEC overflow
        '{1'b1, OP_INC,  8'hFF, 8'h00, 8'h00, 6'b100011, 4'd6},  // R6 wrap, C kept
        '{1'b0, OP_LSL,  8'h88, 8'h00, 8'h10, 6'b111001, 4'd7},  // R7 LSL
        '{1'b1, OP_ROL,  8'h40, 8'h00, 8'h81, 6'b001100, 4'd7},  // R7 ROL carry in
        '{1'b1, OP_LSR,  8'h01, 8'h00, 8'h00, 6'b111011, 4'd8},  // R8 LSR
        '{1'b0, OP_ASR,  8'h81, 8'h00, 8'hC0, 6'b010101, 4'd8},  // R8 ASR
        '{1'b1, OP_ROR,  8'h02, 8'h00, 8'h81, 6'b101100, 4'd8},  // R8 ROR carry in
        '{1'b1, OP_SWAP, 8'h3C, 8'h00, 8'hC3, 6'b100011, 4'd9},  // R9 swap
        '{1'b0, OP_SWAP, 8'hA5, 8'h00, 8'h5A, 6'b000010, 4'd9},  // R9 swap
        '{1'b1, OP_NOP,  8'h77, 8'h00, 8'h77, 6'b100011, 4'd9},  // R9 no-op
        '{1'b0, OP_ADD,  8'h80, 8'h80, 8'h00, 6'b011011, 4'd2}   // R2 carry, overflow, zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = OP_NOP;
    logic [7:0]  opa_i = '0, opa_hi_i = '0, opb_i = '0;
    logic [7:0]  res_o;
    logic [5:0]  flags_o;
    logic        busy_o, word_done_o;
    logic [15:0] word_o;
    int          n_chk = 0, n_err = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    alu8_flags uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i),
        .opa_hi_i(opa_hi_i), .opb_i(opb_i), .res_o(res_o), .flags_o(flags_o),
        .busy_o(busy_o), .word_o(word_o), .word_done_o(word_done_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Apply one byte operation for one clock; sample after the edge.
    task automatic step(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b;
        @(posedge clk);
        #1;
    endtask

    // Preset flags: 0 gives {H,S,V,N,Z,C}=000010, 1 gives 100011.
    task automatic preset(input logic which);
        if (which) step(OP_ADD, 8'hFF, 8'h01);
        else       step(OP_ADD, 8'h00, 8'h00);
    endtask

    // Two-cycle word op; an ignored byte op is driven during the busy cycle.
    task automatic word_op(input logic sub, input logic [15:0] pair, input logic [7:0] imm,
                           input logic [15:0] exp_w, input logic [5:0] exp_f);
        @(negedge clk);
        op_i = sub ? OP_WSUB : OP_WADD;
        opa_hi_i = pair[15:8]; opa_i = pair[7:0]; opb_i = imm;
        @(posedge clk); #1;
        chk("R11 busy after start", {15'd0, busy_o}, 16'd1);
        chk("R11 no done at start", {15'd0, word_done_o}, 16'd0);
        @(negedge clk);
        op_i = OP_NEG; opa_i = 8'h00; opa_hi_i = 8'h00; opb_i = 8'h00;
        @(posedge clk); #1;
        chk("R11 busy cleared", {15'd0, busy_o}, 16'd0);
        chk("R11 done pulse", {15'd0, word_done_o}, 16'd1);
        chk("R11 word result", word_o, exp_w);
        chk("R11 word flags", {10'd0, flags_o}, {10'd0, exp_f});
        step(OP_NOP, 8'h00, 8'h00);
        chk("R11 done one cycle", {15'd0, word_done_o}, 16'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flags", {10'd0, flags_o}, 16'd0);
        chk("R1 reset busy", {15'd0, busy_o}, 16'd0);
        chk("R1 reset word", word_o, 16'd0);
        chk("R1 reset done", {15'd0, word_done_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [5:0] pre_f;
            pre_f = VEC[i].pre ? 6'b100011 : 6'b000010;
            preset(VEC[i].pre);
            @(negedge clk);
            op_i = VEC[i].op; opa_i = VEC[i].a; opb_i = VEC[i].b;
            #2;
            // R12: result valid now, flags still hold the preset
            chk($sformatf("R%0d result vec %0d", VEC[i].req, i), {8'd0, res_o}, {8'd0, VEC[i].res});
            chk($sformatf("R12 flags before edge vec %0d", i), {10'd0, flags_o}, {10'd0, pre_f});
            @(posedge clk); #1;
            chk($sformatf("R%0d flags vec %0d", VEC[i].req, i), {10'd0, flags_o}, {10'd0, VEC[i].fl});
        end

        // R10 sign follows N xor V after a chain without presets
        step(OP_SUB, 8'h80, 8'h01);
        step(OP_DEC, 8'h00, 8'h00);
        chk("R10 sign after chain", {15'd0, flags_o[4]}, {15'd0, flags_o[2] ^ flags_o[3]});

        // R11 word operations, H must be kept
        preset(1'b1);
        word_op(1'b0, 16'h12F0, 8'h20, 16'h1310, 6'b100000);
        preset(1'b0);
        word_op(1'b0, 16'hFFFF, 8'h01, 16'h0000, 6'b000011);
        preset(1'b0);
        word_op(1'b1, 16'h8000, 8'h01, 16'h7FFF, 6'b011000);
        preset(1'b1);
        word_op(1'b1, 16'h0000, 8'h01, 16'hFFFF, 6'b110101);

        // R1 reset in the middle of operation clears the flags
        preset(1'b1);
        @(negedge clk);
        rst_n = 1'b0; op_i = OP_NOP;
        @(posedge clk); #1;
        chk("R1 reset mid-run flags", {10'd0, flags_o}, 16'd0);
        chk("R1 reset mid-run word", word_o, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule